// File: doc/BRIEF.md
# ADC Result Block Transfer Controller

This block moves conversion results into memory with no processor in the loop. Each time the conversion controller strobes a new result, the block issues one 16-bit write on a simple memory port. The write address starts at a programmable base and advances by two bytes per transfer. An 8-bit transfer count sets how many results make up a block. A count of zero switches the whole controller off.

Two mode bits shape a run. The buffer bit selects one block or two back-to-back blocks for ping-pong use, with the second block starting right after the first. The continuous bit makes the run restart from the base address after the last block, instead of stopping there. At the end of each block the controller pulses a block-complete flag for the interrupt logic. A write to the base-address register or to the count register re-arms the run from the base address. A result that arrives while the previous write still waits for its acknowledge is dropped, and this raises a sticky overflow bit.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: When the transfer count register is 0, results cause no memory write and `xfer_active` is 0.
- R2: Each accepted result produces one write request that carries the result as data. The address is base + 2*k, where k counts the transfers since the run was armed (continuing across the block boundary). The request, address and data hold steady until `mem_ack` is seen high at a clock edge.
- R3: A result that arrives while a write request is pending and is not acknowledged in that cycle is dropped, and the address does not advance. `overflow` goes to 1 and stays 1 until the base address or the count is written.
- R4: With `mode_two_blk`=0 and `mode_cont`=0, the run stops after `count` transfers. `xfer_active` then goes to 0 and later results are ignored.
- R5: With `mode_two_blk`=1, the second block continues at base + 2*count. `cur_blk` is 0 while the first block fills and 1 while the second fills. Without continuous mode, the run stops after both blocks.
- R6: `blk_done` is a one-cycle pulse in the cycle after the last write of a block is acknowledged. It pulses once per block and never for other transfers.
- R7: With `mode_cont`=1, the write after the last block goes to the base address again with `cur_blk`=0. If `mode_cont` is cleared during a run, the run stops at the end of the final block of that pass.
- R8: A base-address write loads the new base, resets the in-block transfer count and `cur_blk`, and arms the run. The next result goes to the new base.
- R9: After reset the base address is 0x200, the count is 0 and both mode bits are 0. `mem_req`, `blk_done`, `overflow`, `cur_blk` and `xfer_active` are 0.
- R10: A write of a non-zero count arms a run at the current base address. The first result of the new run goes to that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_we | input | 1 | Write strobe for the transfer count register |
| cnt_wdata | input | 8 | Transfers per block (0 disables) |
| mode_we | input | 1 | Write strobe for the mode bits |
| mode_two_blk | input | 1 | Mode data: 1 = two-block buffering |
| mode_cont | input | 1 | Mode data: 1 = continuous restart |
| base_we | input | 1 | Write strobe for the base address register |
| base_wdata | input | 16 | Base byte address |
| res_valid | input | 1 | One-cycle strobe: new conversion result |
| res_data | input | 16 | Conversion result |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 16 | Write byte address |
| mem_data | output | 16 | Write data |
| mem_ack | input | 1 | Write accepted at this edge |
| blk_done | output | 1 | Block-complete pulse |
| cur_blk | output | 1 | Block being filled (0 or 1) |
| overflow | output | 1 | Sticky: a result was dropped |
| xfer_active | output | 1 | A run is armed and accepting results |

## Verification
The hardest situation to reach is the overflow drop. A result must arrive while an earlier write is still unacknowledged. The bench memory model can stall its acknowledge, so a second result is sent into that window. The bench then checks that the dropped value never reaches memory and that the next accepted result lands on the address the dropped one would have taken. The continuous-mode wrap followed by clearing the continuous bit mid-pass is the other deep case. The bench reaches it by sending results until the pointer has wrapped twice, and only then clearing the bit.

// File: rtl/adc_xfer_pkg.sv
// Shared types for the ADC result block transfer controller.
package adc_xfer_pkg;

    // Run shape selected by the mode register.
    typedef struct packed {
        logic two_blk;  // 1: two blocks back to back
        logic cont;     // 1: restart from base after the last block
    } xfer_mode_t;

endpackage

// File: rtl/adc_xfer_regs.sv
// Configuration registers: transfer count, mode bits and base address.
// Assumes: write strobes are single-cycle and synchronous to clk.
module adc_xfer_regs
    import adc_xfer_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         CNT_W     = 8,
    parameter logic [15:0] BASE_RST = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              mode_we,
    input  xfer_mode_t        mode_wdata,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic [CNT_W-1:0]  cnt,
    output xfer_mode_t        mode,
    output logic [ADDR_W-1:0] base
);

    // Register the three configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            mode <= '0;
            base <= ADDR_W'(BASE_RST);
        end else begin
            if (cnt_we)  cnt  <= cnt_wdata;
            if (mode_we) mode <= mode_wdata;
            if (base_we) base <= base_wdata;
        end
    end

endmodule

// File: rtl/adc_xfer_seq.sv
// Address and block sequencer: tracks the write pointer, the position in
// the block, the current block and whether a run is armed.
// Assumes: take is never high in a cycle with cnt_we or base_we.
module adc_xfer_seq
    import adc_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  xfer_mode_t        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              take,
    output logic [ADDR_W-1:0] ptr,
    output logic              last,
    output logic              blk,
    output logic              run
);

    logic [CNT_W-1:0] done_cnt;
    logic             final_blk;

    // Decode the block boundary for the transfer being taken now.
    always_comb begin
        last      = (done_cnt == cnt - CNT_W'(1));
        final_blk = !mode.two_blk || blk;
    end

    // Advance pointer and counters on each taken result; rearm on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            done_cnt <= '0;
            blk      <= 1'b0;
            run      <= 1'b0;
        end else if (base_we) begin
            ptr      <= base_wdata;
            done_cnt <= '0;
            blk      <= 1'b0;
            run      <= (cnt_we ? cnt_wdata : cnt) != '0;
        end else if (cnt_we) begin
            ptr      <= base;
            done_cnt <= '0;
            blk      <= 1'b0;
            run      <= cnt_wdata != '0;
        end else if (take) begin
            if (!last) begin
                ptr      <= ptr + ADDR_W'(STEP);
                done_cnt <= done_cnt + CNT_W'(1);
            end else begin
                done_cnt <= '0;
                if (!final_blk) begin
                    blk <= 1'b1;
                    ptr <= ptr + ADDR_W'(STEP);
                end else if (mode.cont) begin
                    blk <= 1'b0;
                    ptr <= base;
                end else begin
                    run <= 1'b0;
                    ptr <= ptr + ADDR_W'(STEP);
                end
            end
        end
    end

    // R1: a zero count never leaves a run armed.
    p_idle_when_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !run);

endmodule

// File: rtl/adc_xfer_wport.sv
// Memory write port: holds one pending write until acknowledged, flags a
// dropped result, and pulses block-complete when a block's last write lands.
// Assumes: mem_ack is only meaningful while mem_req is high.
module adc_xfer_wport #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              drop,
    input  logic              clr_ovf,
    input  logic              last_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              busy,
    output logic              blk_done,
    output logic              overflow
);

    logic last_q;

    // A slot is busy while a request waits for its acknowledge.
    always_comb busy = mem_req && !mem_ack;

    // Load a new write or retire the pending one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            last_q   <= 1'b0;
        end else if (take) begin
            mem_req  <= 1'b1;
            mem_addr <= addr_in;
            mem_data <= data_in;
            last_q   <= last_in;
        end else if (mem_req && mem_ack) begin
            mem_req  <= 1'b0;
        end
    end

    // Pulse block-complete once the final write of a block is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_done <= 1'b0;
        else        blk_done <= mem_req && mem_ack && last_q;
    end

    // Sticky overflow on a dropped result, cleared on rearm.
    always_ff @(posedge clk) begin
        if (!rst_n)       overflow <= 1'b0;
        else if (clr_ovf) overflow <= 1'b0;
        else if (drop)    overflow <= 1'b1;
    end

    // R2: a pending request holds address and data until acknowledged.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    // R6: block-complete only follows an acknowledged write.
    p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(mem_req && mem_ack));

endmodule

// File: rtl/adc_xfer_ctrl.sv
// Top of the ADC result block transfer controller. Joins the configuration
// registers, the address sequencer and the memory write port.
// Assumes: res_valid is a one-cycle strobe per conversion result.
module adc_xfer_ctrl
    import adc_xfer_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 16,
    parameter int          CNT_W    = 8,
    parameter logic [15:0] BASE_RST = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              mode_we,
    input  logic              mode_two_blk,
    input  logic              mode_cont,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ack,
    output logic              blk_done,
    output logic              cur_blk,
    output logic              overflow,
    output logic              xfer_active
);

    localparam int STEP = DATA_W / 8;

    logic [CNT_W-1:0]  cnt;
    xfer_mode_t        mode;
    xfer_mode_t        mode_wdata;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ptr;
    logic              last;
    logic              run;
    logic              busy;
    logic              take;
    logic              drop;
    logic              cfg_hit;

    // Gather the mode write data and decide the fate of each result.
    always_comb begin
        mode_wdata.two_blk = mode_two_blk;
        mode_wdata.cont    = mode_cont;
        cfg_hit            = cnt_we || base_we;
        take               = res_valid && run && !busy && !cfg_hit;
        drop               = res_valid && run && busy && !cfg_hit;
        xfer_active        = run;
    end

    adc_xfer_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_RST(BASE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .cnt(cnt), .mode(mode), .base(base)
    );

    adc_xfer_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cnt(cnt), .mode(mode), .base(base),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .take(take), .ptr(ptr), .last(last), .blk(cur_blk), .run(run)
    );

    adc_xfer_wport #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_wport (
        .clk(clk), .rst_n(rst_n),
        .take(take), .drop(drop), .clr_ovf(cfg_hit),
        .last_in(last), .addr_in(ptr), .data_in(res_data),
        .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_data(mem_data), .busy(busy), .blk_done(blk_done),
        .overflow(overflow)
    );

    // R3: overflow only rises after a result strobe.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(res_valid));

    // R4: an idle controller issues no new request.
    p_no_req_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !mem_req) |=> !mem_req);

endmodule

// File: tb/tb_adc_xfer_ctrl.sv
// Directed bench for the ADC result block transfer controller.
module tb_adc_xfer_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_we = 1'b0;
    logic [7:0]  cnt_wdata = '0;
    logic        mode_we = 1'b0;
    logic        mode_two_blk = 1'b0;
    logic        mode_cont = 1'b0;
    logic        base_we = 1'b0;
    logic [15:0] base_wdata = '0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_data;
    logic        mem_ack;
    logic        blk_done;
    logic        cur_blk;
    logic        overflow;
    logic        xfer_active;

    int checks = 0;
    int fails = 0;
    logic stall = 1'b0;
    logic [15:0] log_addr [0:63];
    logic [15:0] log_data [0:63];
    int log_n = 0;
    int done_n = 0;
    logic log_clr = 1'b0;

    always #4 clk = ~clk;

    adc_xfer_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .mode_we(mode_we), .mode_two_blk(mode_two_blk), .mode_cont(mode_cont),
        .base_we(base_we), .base_wdata(base_wdata),
        .res_valid(res_valid), .res_data(res_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ack(mem_ack), .blk_done(blk_done), .cur_blk(cur_blk),
        .overflow(overflow), .xfer_active(xfer_active)
    );

    // Memory model: acknowledge one cycle after a request, log accepted writes.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack && !stall;
        if (log_clr) begin
            log_n  <= 0;
            done_n <= 0;
        end else begin
            if (rst_n && mem_req && mem_ack && log_n < 64) begin
                log_addr[log_n] <= mem_addr;
                log_data[log_n] <= mem_data;
                log_n <= log_n + 1;
            end
            if (blk_done) done_n <= done_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wr_mode(input logic two, input logic cont);
        @(negedge clk); mode_we = 1'b1; mode_two_blk = two; mode_cont = cont;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_base(input logic [15:0] v);
        @(negedge clk); base_we = 1'b1; base_wdata = v;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] d);
        @(negedge clk); res_valid = 1'b1; res_data = d;
        @(negedge clk); res_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_write(input string req, input int idx, input int a, input int d);
        chk({req, " addr"}, int'(log_addr[idx]), a);
        chk({req, " data"}, int'(log_data[idx]), d);
    endtask

    // R9 and R1: idle after reset; zero count ignores results.
    task automatic t_reset();
        chk("R9 mem_req", int'(mem_req), 0);
        chk("R9 overflow", int'(overflow), 0);
        chk("R9 cur_blk", int'(cur_blk), 0);
        chk("R9 blk_done", int'(blk_done), 0);
        chk("R9 xfer_active", int'(xfer_active), 0);
        clear_log();
        send(16'h1111);
        send(16'h2222);
        chk("R1 no writes with count 0", log_n, 0);
        chk("R1 inactive", int'(xfer_active), 0);
    endtask

    // R4, R10, R6, R9: one block at the reset base.
    task automatic t_one_block();
        clear_log();
        wr_cnt(8'd3);
        chk("R10 armed", int'(xfer_active), 1);
        for (int i = 0; i < 4; i++) send(16'hA000 + 16'(i));
        chk("R4 write count", log_n, 3);
        for (int i = 0; i < 3; i++) chk_write("R9 R2", i, 'h200 + 2*i, 'hA000 + i);
        chk("R6 one done", done_n, 1);
        chk("R4 stopped", int'(xfer_active), 0);
    endtask

    // R5, R6, R8: two blocks back to back.
    task automatic t_two_block();
        clear_log();
        wr_cnt(8'd2);
        wr_mode(1'b1, 1'b0);
        wr_base(16'h0300);
        send(16'hB000);
        send(16'hB001);
        chk("R5 second block selected", int'(cur_blk), 1);
        chk("R6 done after block 0", done_n, 1);
        for (int i = 2; i < 5; i++) send(16'hB000 + 16'(i));
        chk("R5 write count", log_n, 4);
        for (int i = 0; i < 4; i++) chk_write("R5", i, 'h300 + 2*i, 'hB000 + i);
        chk("R6 two dones", done_n, 2);
        chk("R5 stopped", int'(xfer_active), 0);
    endtask

    // R7: continuous wrap, then clearing the bit ends the pass.
    task automatic t_continuous();
        clear_log();
        wr_mode(1'b0, 1'b1);
        wr_base(16'h0400);
        for (int i = 0; i < 5; i++) send(16'hC000 + 16'(i));
        chk("R7 still active", int'(xfer_active), 1);
        chk_write("R7 wrap", 2, 'h400, 'hC002);
        chk_write("R7 wrap", 4, 'h400, 'hC004);
        chk("R7 dones", done_n, 2);
        wr_mode(1'b0, 1'b0);
        send(16'hC005);
        send(16'hC006);
        chk("R7 writes", log_n, 6);
        chk_write("R7 finish", 5, 'h402, 'hC005);
        chk("R7 stopped", int'(xfer_active), 0);
        chk("R6 final done", done_n, 3);
    endtask

    // R8: base write mid-block reloads the pointer.
    task automatic t_reload();
        clear_log();
        wr_cnt(8'd4);
        wr_base(16'h0500);
        send(16'hD000);
        send(16'hD001);
        wr_base(16'h0600);
        send(16'hD002);
        chk("R8 writes", log_n, 3);
        chk_write("R8 reload", 2, 'h600, 'hD002);
        chk("R8 block reset", int'(cur_blk), 0);
    endtask

    // R3: overflow on a result during a stalled write.
    task automatic t_overflow();
        clear_log();
        wr_base(16'h0700);
        stall = 1'b1;
        send(16'hE000);
        chk("R3 no overflow yet", int'(overflow), 0);
        send(16'hE001);
        chk("R3 overflow set", int'(overflow), 1);
        stall = 1'b0;
        repeat (3) @(negedge clk);
        send(16'hE002);
        chk("R3 writes", log_n, 2);
        chk_write("R3 first", 0, 'h700, 'hE000);
        chk_write("R3 next addr", 1, 'h702, 'hE002);
        chk("R3 sticky", int'(overflow), 1);
        wr_base(16'h0700);
        chk("R3 cleared by base write", int'(overflow), 0);
    endtask

    // R1: count 0 mid-run disables.
    task automatic t_disable();
        clear_log();
        wr_cnt(8'd0);
        chk("R1 inactive after zero", int'(xfer_active), 0);
        send(16'hF000);
        chk("R1 no write", log_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_one_block();
        t_two_block();
        t_continuous();
        t_reload();
        t_overflow();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule